// File: doc/BRIEF.md
# Output Impedance Calibration Controller

This block keeps the pull-up and pull-down legs of an output driver matched to a target drive strength. A free-running cycle counter fires an evaluation strobe once per programmable period and then starts counting again. At each strobe the block samples a per-leg comparator indication. The indication says whether that leg should get stronger, get weaker or stay as it is. The block then moves that leg's binary-weighted code by at most one step. Codes saturate at both ends and never wrap.

A new code must not reach a leg while that leg is conducting, because a change there would glitch the pad. The block therefore watches the driver's present state. A pull-down change is applied only while the pad drives a 1 or floats. A pull-up change is applied only while the pad drives a 0 or floats. A change that cannot be applied at once is held as pending and applied at the first legal cycle. A later evaluation overwrites the pending value.

Top module: `imp_cal_ctrl`

## Requirements
- R1: The evaluation strobe fires every EVAL_PERIOD cycles. After reset is released, the first evaluation samples the step flags at rising edge number EVAL_PERIOD+1, and later evaluations come every EVAL_PERIOD edges. An evaluation that can be applied at once changes the output code at that edge.
- R2: The step flags are 2 bits per leg: 01 = up (code+1), 10 = down (code-1), 00 and 11 = hold. Each evaluation moves a leg's applied code by at most one step from its current applied value.
- R3: The 5-bit codes saturate: up at 31 stays 31 and down at 0 stays 0. A code never wraps.
- R4: The driver state input is 2 bits: 00 = high-Z, 01 = driving 1, 10 = driving 0, 11 = reserved (legal for neither leg). The pull-down code changes only at an edge where the state is 00 or 01.
- R5: The pull-up code changes only at an edge where the state is 00 or 10.
- R6: A change that is blocked by the driver state stays pending across cycles. It is applied at the first edge where the state is legal for that leg.
- R7: A newer evaluation replaces a pending value with one step from the currently applied code.
- R8: A hold evaluation leaves the applied code unchanged and discards any pending change.
- R9: Reset is synchronous and active high. It loads both codes with mid-scale 16 and clears all pending changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pu_step | input | 2 | Pull-up comparator indication (01 up, 10 down, else hold) |
| pd_step | input | 2 | Pull-down comparator indication (01 up, 10 down, else hold) |
| drv_state | input | 2 | Driver state: 00 high-Z, 01 driving 1, 10 driving 0, 11 reserved |
| pu_code | output | 5 | Applied pull-up code |
| pd_code | output | 5 | Applied pull-down code |

## Verification
The bench uses a short evaluation period. It runs a cycle-exact arithmetic reference of both legs and compares the codes on every cycle. It first checks the exact edge of the first evaluation, so an off-by-one counter shows up as a code that moves one cycle early or late. It then drives both codes into saturation at each end; a design that wraps would jump between 0 and 31. It holds the driver in a state that blocks one leg while the other leg keeps moving, then opens the blocked leg for a single cycle. A design that applies changes while the leg is conducting, or that loses pending values, diverges there. Pending values are then overwritten by a later evaluation or discarded by a hold evaluation, which exposes designs that stack several steps or keep stale values. A long pseudo-random phase mixes all flag and state codes, including the reserved ones.

// File: rtl/imp_cal_pkg.sv
package imp_cal_pkg;

    localparam int CODE_W   = 5;
    localparam int CODE_MAX = (1 << CODE_W) - 1;
    localparam logic [CODE_W-1:0] CODE_MID = CODE_W'(1 << (CODE_W - 1));

    typedef logic [CODE_W-1:0] code_t;

    typedef enum logic [1:0] {
        STEP_HOLD = 2'b00,
        STEP_UP   = 2'b01,
        STEP_DOWN = 2'b10,
        STEP_RSV  = 2'b11
    } step_e;

    typedef enum logic [1:0] {
        DRV_HIZ  = 2'b00,
        DRV_ONE  = 2'b01,
        DRV_ZERO = 2'b10,
        DRV_RSV  = 2'b11
    } drv_e;

    typedef enum logic {
        LEG_PULL_DOWN = 1'b0,
        LEG_PULL_UP   = 1'b1
    } leg_kind_e;

    typedef struct packed {
        code_t applied;
        logic  pend_v;
        code_t pend;
    } leg_state_t;

    // One saturating step of a code in the requested direction.
    function automatic code_t step_code(input code_t cur, input step_e dir);
        code_t nxt;
        nxt = cur;
        unique case (dir)
            STEP_UP:   if (cur != code_t'(CODE_MAX)) nxt = cur + code_t'(1);
            STEP_DOWN: if (cur != '0)                nxt = cur - code_t'(1);
            default:   nxt = cur;
        endcase
        return nxt;
    endfunction

    // Whether a leg may take a new code while the driver is in this state.
    function automatic logic leg_may_update(input leg_kind_e kind, input drv_e st);
        logic ok;
        if (kind == LEG_PULL_UP) ok = (st == DRV_HIZ) || (st == DRV_ZERO);
        else                     ok = (st == DRV_HIZ) || (st == DRV_ONE);
        return ok;
    endfunction

endpackage

// File: rtl/imp_cal_timer.sv
module imp_cal_timer #(
    parameter int EVAL_PERIOD = 1024
) (
    input  logic clk,
    input  logic rst,
    output logic eval_tick
);
    localparam int CNT_W = (EVAL_PERIOD > 1) ? $clog2(EVAL_PERIOD) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(EVAL_PERIOD - 1);

    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt       <= '0;
            eval_tick <= 1'b0;
        end else begin
            eval_tick <= (cnt == LAST);
            cnt       <= (cnt == LAST) ? '0 : cnt + CNT_W'(1);
        end
    end

    // R1: the strobe follows a counter that had reached its last value
    p_tick_after_last_r1: assert property (@(posedge clk) disable iff (rst)
        $rose(eval_tick) |-> $past(cnt) == LAST);

    generate
        if (EVAL_PERIOD > 1) begin : g_single
            // R1: strobes are isolated single cycles when the period exceeds one
            p_tick_single_r1: assert property (@(posedge clk) disable iff (rst)
                eval_tick |=> !eval_tick);
        end
    endgenerate

endmodule

// File: rtl/imp_cal_leg.sv
module imp_cal_leg
    import imp_cal_pkg::*;
#(
    parameter leg_kind_e KIND = LEG_PULL_DOWN
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  eval_tick,
    input  step_e step,
    input  drv_e  drv,
    output code_t code
);
    leg_state_t cur, nxt;
    code_t      cand;
    logic       safe;

    assign safe = leg_may_update(KIND, drv);
    assign cand = step_code(cur.applied, step);

    always_comb begin
        nxt = cur;
        if (eval_tick) begin
            if (cand == cur.applied) begin
                nxt.pend_v = 1'b0;
            end else if (safe) begin
                nxt.applied = cand;
                nxt.pend_v  = 1'b0;
            end else begin
                nxt.pend   = cand;
                nxt.pend_v = 1'b1;
            end
        end else if (cur.pend_v && safe) begin
            nxt.applied = cur.pend;
            nxt.pend_v  = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cur.applied <= CODE_MID;
            cur.pend_v  <= 1'b0;
            cur.pend    <= CODE_MID;
        end else begin
            cur <= nxt;
        end
    end

    assign code = cur.applied;

    // R2: the applied code moves by at most one step per cycle
    p_one_step_r2: assert property (@(posedge clk) disable iff (rst)
        (code == $past(code)) || (code == $past(code) + code_t'(1))
        || (code == $past(code) - code_t'(1)));

    // R3: no wrap across the ends of the range
    p_no_wrap_r3: assert property (@(posedge clk) disable iff (rst)
        !(($past(code) == code_t'(CODE_MAX) && code == '0)
          || ($past(code) == '0 && code == code_t'(CODE_MAX))));

    // R6: a blocked pending change leaves the code alone until legal
    p_pend_waits_r6: assert property (@(posedge clk) disable iff (rst)
        (cur.pend_v && !safe && !eval_tick) |=> $stable(code));

    // R8: a hold evaluation clears the pending flag
    p_hold_clears_r8: assert property (@(posedge clk) disable iff (rst)
        (eval_tick && (step == STEP_HOLD || step == STEP_RSV)) |=> !cur.pend_v);

    // R9: reset loads mid-scale with nothing pending
    p_reset_mid_r9: assert property (@(posedge clk)
        $past(rst) |-> (code == CODE_MID && !cur.pend_v));

endmodule

// File: rtl/imp_cal_ctrl.sv
module imp_cal_ctrl
    import imp_cal_pkg::*;
#(
    parameter int EVAL_PERIOD = 1024
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [1:0]          pu_step,
    input  logic [1:0]          pd_step,
    input  logic [1:0]          drv_state,
    output logic [CODE_W-1:0]   pu_code,
    output logic [CODE_W-1:0]   pd_code
);
    logic  eval_tick;
    drv_e  drv;
    step_e leg_step [2];
    code_t leg_code [2];

    assign drv         = drv_e'(drv_state);
    assign leg_step[0] = step_e'(pd_step);
    assign leg_step[1] = step_e'(pu_step);

    imp_cal_timer #(.EVAL_PERIOD(EVAL_PERIOD)) u_timer (
        .clk       (clk),
        .rst       (rst),
        .eval_tick (eval_tick)
    );

    generate
        for (genvar g = 0; g < 2; g++) begin : g_leg
            imp_cal_leg #(.KIND(g == 1 ? LEG_PULL_UP : LEG_PULL_DOWN)) u_leg (
                .clk       (clk),
                .rst       (rst),
                .eval_tick (eval_tick),
                .step      (leg_step[g]),
                .drv       (drv),
                .code      (leg_code[g])
            );
        end
    endgenerate

    assign pd_code = leg_code[0];
    assign pu_code = leg_code[1];

    // R4: pull-down changes only when the pad drives 1 or floats
    p_pd_safe_r4: assert property (@(posedge clk) disable iff (rst)
        (pd_code != $past(pd_code)) |->
        ($past(drv_state) == 2'b00 || $past(drv_state) == 2'b01));

    // R5: pull-up changes only when the pad drives 0 or floats
    p_pu_safe_r5: assert property (@(posedge clk) disable iff (rst)
        (pu_code != $past(pu_code)) |->
        ($past(drv_state) == 2'b00 || $past(drv_state) == 2'b10));

endmodule

// File: tb/tb_imp_cal_ctrl.sv
module tb_imp_cal_ctrl;
    localparam int P = 8;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [1:0] pu_step = 2'b00;
    logic [1:0] pd_step = 2'b00;
    logic [1:0] drv_state = 2'b00;
    logic [4:0] pu_code, pd_code;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #5 clk = ~clk;

    imp_cal_ctrl #(.EVAL_PERIOD(P)) dut (
        .clk(clk), .rst(rst), .pu_step(pu_step), .pd_step(pd_step),
        .drv_state(drv_state), .pu_code(pu_code), .pd_code(pd_code)
    );

    // Arithmetic reference built from the requirements
    int m_cnt, m_tick;
    int m_pu, m_pd, m_pu_pv, m_pd_pv, m_pu_pend, m_pd_pend;

    function automatic int stepped(int c, logic [1:0] s);
        if (s == 2'b01) return (c < 31) ? c + 1 : c;
        if (s == 2'b10) return (c > 0) ? c - 1 : c;
        return c;
    endfunction

    always @(posedge clk) begin
        int n;
        bit pu_ok, pd_ok;
        if (rst) begin
            m_cnt = 0; m_tick = 0;
            m_pu = 16; m_pd = 16; m_pu_pv = 0; m_pd_pv = 0;
            m_pu_pend = 16; m_pd_pend = 16;
        end else begin
            pd_ok = (drv_state == 2'b00) || (drv_state == 2'b01);
            pu_ok = (drv_state == 2'b00) || (drv_state == 2'b10);
            if (m_tick != 0) begin
                n = stepped(m_pd, pd_step);
                if (n == m_pd) m_pd_pv = 0;
                else if (pd_ok) begin m_pd = n; m_pd_pv = 0; end
                else begin m_pd_pend = n; m_pd_pv = 1; end
                n = stepped(m_pu, pu_step);
                if (n == m_pu) m_pu_pv = 0;
                else if (pu_ok) begin m_pu = n; m_pu_pv = 0; end
                else begin m_pu_pend = n; m_pu_pv = 1; end
            end else begin
                if (m_pd_pv != 0 && pd_ok) begin m_pd = m_pd_pend; m_pd_pv = 0; end
                if (m_pu_pv != 0 && pu_ok) begin m_pu = m_pu_pend; m_pu_pv = 0; end
            end
            m_tick = (m_cnt == P - 1) ? 1 : 0;
            m_cnt  = (m_cnt == P - 1) ? 0 : m_cnt + 1;
        end
    end

    task automatic chk(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    task automatic run(input int n, input string tag);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            chk(tag, "pu_code", int'(pu_code), m_pu);
            chk(tag, "pd_code", int'(pd_code), m_pd);
        end
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int keep;
        logic [15:0] lfsr;
        pu_step = 2'b01; pd_step = 2'b10; drv_state = 2'b00;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R9: reset values
        chk("R9", "pu_code", int'(pu_code), 16);
        chk("R9", "pd_code", int'(pd_code), 16);
        // R1: no movement before edge P+1, one step at it
        run(P, "R1");
        chk("R1", "pu_code before first eval", int'(pu_code), 16);
        chk("R1", "pd_code before first eval", int'(pd_code), 16);
        run(1, "R1");
        chk("R1", "pu_code first eval", int'(pu_code), 17);
        chk("R1", "pd_code first eval", int'(pd_code), 15);
        run(P * 20, "R2");
        chk("R3", "pu_code top saturation", int'(pu_code), 31);
        chk("R3", "pd_code bottom saturation", int'(pd_code), 0);
        pu_step = 2'b10; pd_step = 2'b01;
        run(P * 35, "R3");
        chk("R3", "pu_code bottom saturation", int'(pu_code), 0);
        chk("R3", "pd_code top saturation", int'(pd_code), 31);
        // R4: driving 0 blocks pull-down, lets pull-up move
        drv_state = 2'b10; pd_step = 2'b10; pu_step = 2'b01;
        run(P * 3, "R4");
        chk("R4", "pd_code blocked", int'(pd_code), 31);
        chk("R5", "pu_code moves while driving 0", int'(pu_code), 3);
        // R6: one legal cycle releases the pending pull-down change
        drv_state = 2'b01; pu_step = 2'b00;
        run(1, "R6");
        chk("R6", "pd_code after release", int'(pd_code), 30);
        // R7: newer evaluation replaces pending value
        drv_state = 2'b10; pd_step = 2'b01;
        run(P, "R7");
        pd_step = 2'b10;
        run(P, "R7");
        drv_state = 2'b00;
        run(1, "R7");
        chk("R7", "pd_code after replaced pending", int'(pd_code), 29);
        // R8: hold discards pending
        drv_state = 2'b10; pd_step = 2'b01;
        run(P, "R8");
        pd_step = 2'b00;
        run(P, "R8");
        drv_state = 2'b00;
        run(3, "R8");
        chk("R8", "pd_code after hold", int'(pd_code), 29);
        // R5: driving 1 blocks pull-up
        keep = int'(pu_code);
        drv_state = 2'b01; pu_step = 2'b01;
        run(P * 3, "R5");
        chk("R5", "pu_code blocked while driving 1", int'(pu_code), keep);
        drv_state = 2'b11;
        run(P * 2, "R4");
        chk("R5", "pu_code blocked in reserved state", int'(pu_code), keep);
        // Mixed pseudo-random sweep
        lfsr = 16'hACE1;
        for (int i = 0; i < 3000; i++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            pu_step = lfsr[1:0]; pd_step = lfsr[3:2];
            if (lfsr[6:4] != 3'b000) drv_state = lfsr[8:7];
            run(1, "R2");
        end
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule